// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

The engine lays a small 32-bit cursor image over a stream of display pixels. The image sits in an on-chip pixel store of 2048 words, which holds up to 64×32 or 32×64 pixels. A host fills the store one word at a time. It places the data word on one port and an address word carrying a write strobe on another. The same path reaches a 256-word transparency table. Each word of the table holds sixteen 2-bit codes that decide, per cursor pixel, whether that pixel is drawn or the background shows through.

The host sets the cursor's screen position, visible size and enable into shadow registers. These values reach the drawing logic only on a frame-done pulse, so a frame never shows a half-updated cursor. If interlaced scan is selected when the pulse arrives, the vertical position and the height are halved as they are copied. The store has a power-down input and a chip-select input. A power-down clears the table back to its default fill and marks the pixel contents as lost.

Top module: `curs_overlay`

## Requirements
- R1: After reset the cursor is disabled and its pixel contents count as invalid. Every output pixel equals the input pixel from one cycle before, and `out_valid` is low in the first cycle after reset.
- R2: A `cfg_wr` pulse loads position, size and enable into shadow registers and does not change the output. The active values change only on the clock edge at which `frame_done` is high.
- R3: A scan pixel (x, y) lies in the window when X ≤ x < X+W and Y ≤ y < Y+H. Such a pixel may be replaced by a cursor pixel. Every other scan pixel passes through unchanged. X and W come from bits [15:0] of the position and size words; Y and H come from bits [31:16].
- R4: The cursor pixel used at window offset (col, row) is store entry n = row·W + col. A host address maps to n in three parts: address bits [7:0] give n[7:0], address bits [13:12] give n[9:8], and address bits [11:8] select the first half of the store (0xC, n[10]=0) or the second half (0xD, n[10]=1).
- R5: A width of zero or a height of zero shows no cursor, even when the enable bit is set.
- R6: When `interlace` is high at the frame-done edge, the active Y and H are the shadow values shifted right by one bit. X and W are unchanged.
- R7: Host address bits [11:8] = 0xE write transparency table entry [7:0]. After reset every entry holds 0x55555555. The table word for a cursor pixel is picked by pixel bits [31:24], and the 2-bit code in that word is picked by pixel bits [23:20]. The cursor pixel replaces the background only when that code is 01.
- R8: While `sram_pdn` is high or `sram_cs` is low, no cursor is shown and host writes are ignored. A power-down also refills the table with its default. It further hides the cursor until a pixel word has been written again.
- R9: Every output appears exactly one clock after its input. `out_valid` follows `in_valid`, and the background pixel is delayed to match the store read.
- R10: A host write happens only when bit 15 of `host_ctrl` is set. With that bit clear, the address word and data word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load shadow position, size and enable |
| cfg_pos | input | 32 | Screen position: Y in [31:16], X in [15:0] |
| cfg_size | input | 32 | Visible size: height in [31:16], width in [15:0] |
| cfg_en | input | 1 | Cursor enable for the shadow set |
| interlace | input | 1 | Halve vertical geometry at the next frame done |
| frame_done | input | 1 | Copies shadow values to the active set |
| host_wdata | input | 32 | Host data word |
| host_ctrl | input | 16 | Host address [13:0] with write strobe in bit 15 |
| sram_pdn | input | 1 | Store power-down |
| sram_cs | input | 1 | Store chip select |
| in_valid | input | 1 | Scan pixel valid |
| in_x | input | 16 | Scan column |
| in_y | input | 16 | Scan row |
| in_pix | input | 32 | Background pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 32 | Overlaid pixel |

## Verification
The bench loads a full 2048-word image by stepping the banked host address with its own skip rule. It then sweeps every pixel of a screen larger than the window, once with a 64×32 window and once with a 32×64 window. A wrong row stride or a wrong bank mapping shows up in the first sweep as misplaced pixels. The second sweep reads the same store with a different width, which separates the index arithmetic from the addressing. Further full sweeps cover four things: a 3×2 window at the origin, zero-width and zero-height windows, interlaced halving, and a table entry that hides only even-numbered pixels. Together these separate window-edge errors from the transparency decode. Chip-select, power-down and strobe-less sequences then show that writes are dropped and that the cursor stays hidden until the store is reloaded.

// File: rtl/curs_pkg.sv
package curs_pkg;
    // Layout constants fixed by the register and address formats
    localparam int FIELD_W   = 16;               // one coordinate field
    localparam int WORD_W    = 32;               // pixel and table word
    localparam int HADDR_W   = 14;               // host address bits
    localparam int CTRL_W    = 16;               // host control word
    localparam int STB_BIT   = 15;               // write strobe position
    localparam int SUB_W     = 8;                // words per sub-bank (log2)
    localparam int SEL_W     = 2;                // sub-banks per half (log2)
    localparam int LIN_W     = SUB_W + SEL_W + 1; // linear pixel index
    localparam int KEY_W     = 8;                // table index width
    localparam int CODE_W    = 2;                // transparency code width
    localparam int FSEL_W    = 4;                // code field select width
    localparam logic [3:0]        RGN_PIX0 = 4'hC;
    localparam logic [3:0]        RGN_PIX1 = 4'hD;
    localparam logic [3:0]        RGN_TBL  = 4'hE;
    localparam logic [WORD_W-1:0] TBL_FILL = 32'h5555_5555;
    localparam logic [CODE_W-1:0] CODE_SHOW = 2'b01;

    typedef struct packed {
        logic [FIELD_W-1:0] y;
        logic [FIELD_W-1:0] x;
    } pt_t;

    typedef struct packed {
        logic en;
        pt_t  pos;
        pt_t  size;   // y = height, x = width
    } curs_cfg_t;

    typedef enum logic [1:0] {TGT_NONE, TGT_PIX, TGT_TBL} wr_tgt_e;

    typedef struct packed {
        wr_tgt_e          tgt;
        logic [LIN_W-1:0] idx;
    } hwr_t;

    // Turn a host control word into a write target and a linear index
    function automatic hwr_t decode_host(input logic [CTRL_W-1:0] c);
        hwr_t r;
        r.tgt = TGT_NONE;
        r.idx = {c[11:8] == RGN_PIX1, c[13:12], c[7:0]};
        if (c[STB_BIT]) begin
            case (c[11:8])
                RGN_PIX0, RGN_PIX1: r.tgt = TGT_PIX;
                RGN_TBL:            r.tgt = TGT_TBL;
                default:            r.tgt = TGT_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/curs_regs.sv
module curs_regs
    import curs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_pos,
    input  logic [WORD_W-1:0] cfg_size,
    input  logic              cfg_en,
    input  logic              interlace,
    input  logic              frame_done,
    output curs_cfg_t         act_cfg
);
    curs_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            act_cfg <= '0;
        end else begin
            if (cfg_wr) begin
                shadow.en   <= cfg_en;
                shadow.pos  <= cfg_pos;
                shadow.size <= cfg_size;
            end
            if (frame_done) begin
                act_cfg <= shadow;
                if (interlace) begin
                    act_cfg.pos.y  <= {1'b0, shadow.pos.y[FIELD_W-1:1]};
                    act_cfg.size.y <= {1'b0, shadow.size.y[FIELD_W-1:1]};
                end
            end
        end
    end
endmodule

// File: rtl/curs_sram.sv
module curs_sram
    import curs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sram_pdn,
    input  logic              sram_cs,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [CTRL_W-1:0] host_ctrl,
    input  logic              rd_en,
    input  logic [LIN_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic [KEY_W-1:0]  tbl_key,
    output logic [WORD_W-1:0] tbl_word,
    output logic              pix_valid,
    output logic              pix_ok
);
    localparam int PIX_DEPTH = 1 << LIN_W;
    localparam int TBL_DEPTH = 1 << KEY_W;

    logic [WORD_W-1:0] pix_mem [PIX_DEPTH];
    logic [WORD_W-1:0] tbl_mem [TBL_DEPTH];
    hwr_t              req;
    logic              powered;
    logic              unused_ctrl;

    assign req         = decode_host(host_ctrl);
    assign powered     = sram_cs && !sram_pdn;
    assign unused_ctrl = host_ctrl[14];

    // Pixel store: one write port from the host, one read port for the scan
    always_ff @(posedge clk) begin
        if (req.tgt == TGT_PIX && powered)
            pix_mem[req.idx] <= host_wdata;
        if (rd_en)
            rd_data <= pix_mem[rd_idx];
    end

    // Transparency table returns to its default fill on reset and power-down
    always_ff @(posedge clk) begin
        if (rst || sram_pdn) begin
            for (int i = 0; i < TBL_DEPTH; i++)
                tbl_mem[i] <= TBL_FILL;
        end else if (req.tgt == TGT_TBL && powered) begin
            tbl_mem[req.idx[KEY_W-1:0]] <= host_wdata;
        end
    end

    // Pixel contents are lost on power-down until rewritten
    always_ff @(posedge clk) begin
        if (rst || sram_pdn)
            pix_valid <= 1'b0;
        else if (req.tgt == TGT_PIX && powered)
            pix_valid <= 1'b1;
    end

    assign tbl_word = tbl_mem[tbl_key];
    assign pix_ok   = pix_valid && powered;
endmodule

// File: rtl/curs_mix.sv
module curs_mix
    import curs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  curs_cfg_t          act_cfg,
    input  logic               pix_ok,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] in_x,
    input  logic [FIELD_W-1:0] in_y,
    input  logic [WORD_W-1:0]  in_pix,
    output logic               rd_en,
    output logic [LIN_W-1:0]   rd_idx,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [KEY_W-1:0]   tbl_key,
    input  logic [WORD_W-1:0]  tbl_word,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_pix
);
    logic [FIELD_W:0]   x_end, y_end;
    logic               in_win, hit_d;
    logic [LIN_W-1:0]   row, col;
    logic               hit_q;
    logic [WORD_W-1:0]  bg_q;
    logic [CODE_W-1:0]  code;
    logic [FSEL_W:0]    fpos;

    always_comb begin
        x_end  = {1'b0, act_cfg.pos.x} + {1'b0, act_cfg.size.x};
        y_end  = {1'b0, act_cfg.pos.y} + {1'b0, act_cfg.size.y};
        in_win = (in_x >= act_cfg.pos.x) && ({1'b0, in_x} < x_end) &&
                 (in_y >= act_cfg.pos.y) && ({1'b0, in_y} < y_end);
        hit_d  = in_valid && act_cfg.en && pix_ok &&
                 (act_cfg.size.x != '0) && (act_cfg.size.y != '0) && in_win;
        row    = LIN_W'(in_y - act_cfg.pos.y);
        col    = LIN_W'(in_x - act_cfg.pos.x);
        rd_idx = row * act_cfg.size.x[LIN_W-1:0] + col;
        rd_en  = hit_d;
    end

    // Background and hit flag wait one cycle for the store read
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            hit_q     <= 1'b0;
            bg_q      <= '0;
        end else begin
            out_valid <= in_valid;
            hit_q     <= hit_d;
            bg_q      <= in_pix;
        end
    end

    always_comb begin
        tbl_key = rd_data[WORD_W-1 -: KEY_W];
        fpos    = {rd_data[WORD_W-KEY_W-1 -: FSEL_W], 1'b0};
        code    = tbl_word[fpos +: CODE_W];
        out_pix = (hit_q && code == CODE_SHOW) ? rd_data : bg_q;
    end
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
    import curs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_pos,
    input  logic [31:0] cfg_size,
    input  logic        cfg_en,
    input  logic        interlace,
    input  logic        frame_done,
    input  logic [31:0] host_wdata,
    input  logic [15:0] host_ctrl,
    input  logic        sram_pdn,
    input  logic        sram_cs,
    input  logic        in_valid,
    input  logic [15:0] in_x,
    input  logic [15:0] in_y,
    input  logic [31:0] in_pix,
    output logic        out_valid,
    output logic [31:0] out_pix
);
    curs_cfg_t          act_cfg;
    logic               pix_valid, pix_ok, rd_en;
    logic [LIN_W-1:0]   rd_idx;
    logic [WORD_W-1:0]  rd_data, tbl_word;
    logic [KEY_W-1:0]   tbl_key;

    curs_regs u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pos(cfg_pos),
        .cfg_size(cfg_size), .cfg_en(cfg_en), .interlace(interlace),
        .frame_done(frame_done), .act_cfg(act_cfg)
    );

    curs_sram u_sram (
        .clk(clk), .rst(rst), .sram_pdn(sram_pdn), .sram_cs(sram_cs),
        .host_wdata(host_wdata), .host_ctrl(host_ctrl), .rd_en(rd_en),
        .rd_idx(rd_idx), .rd_data(rd_data), .tbl_key(tbl_key),
        .tbl_word(tbl_word), .pix_valid(pix_valid), .pix_ok(pix_ok)
    );

    curs_mix u_mix (
        .clk(clk), .rst(rst), .act_cfg(act_cfg), .pix_ok(pix_ok),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .tbl_key(tbl_key), .tbl_word(tbl_word),
        .out_valid(out_valid), .out_pix(out_pix)
    );
endmodule

// File: rtl/curs_overlay_chk.sv
module curs_overlay_chk
    import curs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frame_done,
    input logic        sram_pdn,
    input logic        sram_cs,
    input logic        in_valid,
    input logic [15:0] in_x,
    input logic [31:0] in_pix,
    input logic        out_valid,
    input logic [31:0] out_pix,
    input curs_cfg_t   act_cfg,
    input logic        pix_valid
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_active_held: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> $stable(act_cfg));
    a_r5_empty_window: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (act_cfg.size.x == '0 || act_cfg.size.y == '0))
        |=> out_pix == $past(in_pix));
    a_r8_dark_store: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (sram_pdn || !sram_cs)) |=> out_pix == $past(in_pix));
    a_r8_contents_lost: assert property (@(posedge clk) disable iff (rst)
        sram_pdn |=> !pix_valid);
    a_r3_left_of_window: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_x < act_cfg.pos.x) |=> out_pix == $past(in_pix));
endmodule

bind curs_overlay curs_overlay_chk u_chk (
    .clk(clk), .rst(rst), .frame_done(frame_done), .sram_pdn(sram_pdn),
    .sram_cs(sram_cs), .in_valid(in_valid), .in_x(in_x), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix), .act_cfg(act_cfg),
    .pix_valid(pix_valid)
);

// File: tb/curs_overlay_bench.sv
module curs_overlay_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_en = 1'b0, interlace = 1'b0, frame_done = 1'b0;
    logic [31:0] cfg_pos = '0, cfg_size = '0, host_wdata = '0, in_pix = '0;
    logic [15:0] host_ctrl = '0, in_x = '0, in_y = '0;
    logic        sram_pdn = 1'b0, sram_cs = 1'b1, in_valid = 1'b0;
    logic        out_valid;
    logic [31:0] out_pix;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [31:0] emem [2048];
    logic [31:0] etbl [256];
    int  s_x, s_y, s_w, s_h;  bit s_en;
    int  m_x, m_y, m_w, m_h;  bit m_en;
    bit  m_valid;

    always #5 clk = ~clk;

    curs_overlay u_curs_overlay (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pos(cfg_pos),
        .cfg_size(cfg_size), .cfg_en(cfg_en), .interlace(interlace),
        .frame_done(frame_done), .host_wdata(host_wdata), .host_ctrl(host_ctrl),
        .sram_pdn(sram_pdn), .sram_cs(sram_cs), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int n);
        logic [31:0] v;
        v[31:24] = n[0] ? 8'h81 : 8'h80;
        v[23:0]  = 24'(n * 37 + 5);
        return v;
    endfunction

    function automatic logic [31:0] bgf(input int x, input int y);
        return 32'h0100_0000 | (32'(y) << 12) | 32'(x);
    endfunction

    function automatic logic [31:0] expect_px(input int x, input int y);
        logic [31:0] v, t;
        int n;
        if (m_en && m_w > 0 && m_h > 0 && m_valid && sram_cs && !sram_pdn &&
            x >= m_x && x < m_x + m_w && y >= m_y && y < m_y + m_h) begin
            n = (y - m_y) * m_w + (x - m_x);
            v = emem[n];
            t = etbl[v[31:24]];
            if (t[2 * v[23:20] +: 2] == 2'b01) return v;
        end
        return bgf(x, y);
    endfunction

    // Next banked host address after one pixel
    function automatic logic [15:0] step_addr(input logic [15:0] a);
        logic [15:0] b;
        b = a + 16'd1;
        if (b[7:0] == 8'h00) b = b + 16'h0F00;
        if ((b & 16'h30FF) == 16'h0000) b = 16'h0D00;
        return b;
    endfunction

    task automatic host_wr(input logic [13:0] addr, input logic [31:0] d, input bit stb);
        @(negedge clk);
        host_wdata = d;
        host_ctrl  = {stb, 1'b0, addr};
        @(negedge clk);
        host_ctrl  = '0;
    endtask

    task automatic load_image(input int count);
        logic [15:0] a;
        a = 16'h0C00;
        for (int n = 0; n < count; n++) begin
            host_wr(a[13:0], pat(n), 1'b1);
            if (sram_cs && !sram_pdn) begin
                emem[n] = pat(n);
                m_valid = 1'b1;
            end
            a = step_addr(a);
        end
    endtask

    task automatic set_cfg(input int x, input int y, input int w, input int h, input bit en);
        @(negedge clk);
        cfg_pos = {16'(y), 16'(x)}; cfg_size = {16'(h), 16'(w)}; cfg_en = en; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        s_x = x; s_y = y; s_w = w; s_h = h; s_en = en;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        m_x = s_x; m_w = s_w; m_en = s_en;
        m_y = interlace ? s_y / 2 : s_y;
        m_h = interlace ? s_h / 2 : s_h;
    endtask

    task automatic sweep(input int sw, input int sh, input string tag);
        logic [31:0] pe;
        bit have;
        have = 1'b0;
        pe = '0;
        for (int y = 0; y < sh; y++) begin
            for (int x = 0; x < sw; x++) begin
                @(negedge clk);
                if (have) check(tag, out_pix, pe);
                in_valid = 1'b1; in_x = 16'(x); in_y = 16'(y); in_pix = bgf(x, y);
                pe = expect_px(x, y);
                have = 1'b1;
            end
        end
        @(negedge clk);
        if (have) check(tag, out_pix, pe);
        in_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) etbl[i] = 32'h5555_5555;
        for (int i = 0; i < 2048; i++) emem[i] = '0;
        m_x = 0; m_y = 0; m_w = 0; m_h = 0; m_en = 0; m_valid = 0;
        s_x = 0; s_y = 0; s_w = 0; s_h = 0; s_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 32'd0);
        sweep(8, 4, "R1 passthrough after reset");

        // R9: valid latency
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); check("R9 valid rises one cycle later", 32'(out_valid), 32'd1);
        in_valid = 1'b0;
        @(negedge clk); check("R9 valid falls one cycle later", 32'(out_valid), 32'd0);

        // R4: full image through banked addressing
        load_image(2048);
        set_cfg(5, 3, 64, 32, 1'b1);
        sweep(80, 40, "R2 shadow not yet applied");
        pulse_frame();
        sweep(80, 40, "R3 R4 window 64x32");
        set_cfg(2, 1, 32, 64, 1'b1);
        pulse_frame();
        sweep(40, 70, "R4 window 32x64");
        set_cfg(0, 0, 3, 2, 1'b1);
        pulse_frame();
        sweep(6, 4, "R3 small window at origin");

        // R5: empty sizes
        set_cfg(4, 4, 0, 5, 1'b1);
        pulse_frame();
        sweep(12, 12, "R5 zero width");
        set_cfg(4, 4, 5, 0, 1'b1);
        pulse_frame();
        sweep(12, 12, "R5 zero height");

        // R6: interlaced halving
        interlace = 1'b1;
        set_cfg(3, 10, 16, 20, 1'b1);
        pulse_frame();
        sweep(24, 20, "R6 interlaced halving");
        interlace = 1'b0;

        // R10: write without strobe
        set_cfg(1, 1, 16, 8, 1'b1);
        pulse_frame();
        host_wr(14'h0C00, 32'h80DE_ADBE, 1'b0);
        sweep(20, 12, "R10 strobe clear ignored");

        // R7: table code hides even pixels
        host_wr(14'h0E80, 32'h5555_5554, 1'b1);
        etbl[8'h80] = 32'h5555_5554;
        sweep(20, 12, "R7 transparency code");

        // R8: chip select off
        @(negedge clk); sram_cs = 1'b0;
        sweep(20, 12, "R8 deselected dark");
        host_wr(14'h0C01, 32'h81BA_D000, 1'b1);
        @(negedge clk); sram_cs = 1'b1;
        sweep(20, 12, "R8 deselected write ignored");

        // R8: power down
        @(negedge clk); sram_pdn = 1'b1;
        m_valid = 1'b0;
        for (int i = 0; i < 256; i++) etbl[i] = 32'h5555_5555;
        host_wr(14'h0E81, 32'h0000_0000, 1'b1);
        sweep(20, 12, "R8 powered down dark");
        @(negedge clk); sram_pdn = 1'b0;
        sweep(20, 12, "R8 contents lost after power-down");
        load_image(128);
        sweep(20, 12, "R8 R7 reload with default table");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule